// File: doc/BRIEF.md
# Management-Frame PHY Register Model

This block stands in for a single Ethernet PHY behind a management-frame register. The host writes a 32-bit frame word. The word holds the operation, a PHY address, a register number and 16 bits of data. The block decodes the word and carries out one register access. For a read, it places the result in the low half of the frame register. It then pulses a done flag that the controller can fold into its event register. Serial bus timing is not modelled, and neither is real autonegotiation. Every access completes in a fixed three-state sequence.

The block also follows a link-state input. On each change of that input it updates the link and autonegotiation-complete status bits and latches the matching interrupt-source events. Those events stay pending until the host reads the interrupt-source register.

The sequencer has three states:
- `ST_IDLE` waits for a frame write. It takes *accept* to `ST_ACCESS`.
- `ST_ACCESS` performs the register read or write. It takes *complete* to `ST_REPORT`.
- `ST_REPORT` raises the done flag for one cycle. It takes *retire* back to `ST_IDLE`.

Top module: `mgmt_phy_model`

## Requirements
- R1: After reset: `op_done` is 0 and `frame_rdata` is 0. Control (reg 0) reads 0x3000, status (reg 1) reads 0x7809 and advertisement (reg 4) reads 0x01E1. Interrupt source (reg 29) and interrupt mask (reg 30) read 0.
- R2: A `frame_wr` seen in `ST_IDLE` is accepted, and `op_done` is high for exactly the second cycle after the accepting edge. A `frame_wr` while the sequencer is busy is ignored.
- R3: A write to reg 0 stores data AND 0x7980. If data bit 12 (autonegotiation enable) is 1, status bit 5 (0x0020) becomes 1 in the same step.
- R4: A write to reg 4 stores (data AND 0x2D7F) OR 0x0080.
- R5: A write to reg 30 stores data bits 7:0. The register reads back with bits 15:8 zero.
- R6: Frame word layout:
  - bit 29 = 1 selects a read;
  - bits 27:23 are the PHY address;
  - bits 22:18 are the register number;
  - bits 15:0 are the data.

  After a read, `frame_rdata` bits 31:16 equal those of the written word and bits 15:0 hold the register value.
- R7: When `link_up` rises, status bits 0x0024 become 1 and interrupt-source bits 7 and 6 become 1.
- R8: When `link_up` falls, status bits 0x0024 become 0 and interrupt-source bit 4 becomes 1.
- R9: A read of reg 29 returns the pending bits and then clears them. A link event in the same cycle as the clearing read is kept.
- R10: A PHY address other than 0, or an unimplemented register, reads as 0 and ignores writes.
- R11: Regs 2 and 3 read as the parameters `PHY_ID_HI` and `PHY_ID_LO` and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_wr | input | 1 | Host writes `frame_wdata` into the frame register |
| frame_wdata | input | 32 | Management frame word |
| frame_rdata | output | 32 | Frame register, low half replaced by read data |
| link_up | input | 1 | Link state of the modelled PHY |
| op_done | output | 1 | One-cycle pulse when an access finishes |

## Verification
A wrong sequencer state shows up as `op_done` missing, doubled or shifted from the second cycle after an accepted write. It also shows up as `frame_rdata` changing during a busy period, and both appear within three cycles of a frame write. A corrupt register, lost pending event or bad mask only shows on the next read of that register. The bench therefore reads back every register after every write across three PHY addresses and several data patterns. It also reads the status and interrupt-source registers right after each link change.

// File: rtl/mphy_pkg.sv
package mphy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_REPORT = 2'd2
    } mphy_state_e;

    localparam int FRAME_W   = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int EVT_W     = 8;
    localparam int RD_BIT    = 29;
    localparam int PHY_LSB   = 23;
    localparam int REG_LSB   = 18;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] REG_IDHI  = 5'd2;
    localparam logic [ADDR_W-1:0] REG_IDLO  = 5'd3;
    localparam logic [ADDR_W-1:0] REG_ADV   = 5'd4;
    localparam logic [ADDR_W-1:0] REG_ISRC  = 5'd29;
    localparam logic [ADDR_W-1:0] REG_IMASK = 5'd30;

    localparam logic [DATA_W-1:0] CTRL_RST  = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST  = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_RST   = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_KEEP = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_KEEP  = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE = 16'h0080;
    localparam logic [DATA_W-1:0] STAT_LINK = 16'h0024;
    localparam logic [DATA_W-1:0] STAT_ANOK = 16'h0020;
    localparam int                CTRL_AN_BIT = 12;
    localparam logic [EVT_W-1:0]  EVT_UP    = 8'hC0;
    localparam logic [EVT_W-1:0]  EVT_DOWN  = 8'h10;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] data;
    } mgmt_cmd_t;

endpackage

// File: rtl/mphy_frame_fsm.sv
module mphy_frame_fsm
    import mphy_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic [DATA_W-1:0]  rd_value,
    output logic [FRAME_W-1:0] frame_q,
    output mgmt_cmd_t          cmd,
    output logic               access,
    output logic               op_done
);

    mphy_state_e state, state_nx;
    logic        accept;

    assign accept = (state == ST_IDLE) && frame_wr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (frame_wr) state_nx = ST_ACCESS;
            ST_ACCESS: state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (accept)
            frame_q <= frame_wdata;
        else if (state == ST_ACCESS && cmd.is_read)
            frame_q[DATA_W-1:0] <= rd_value;
    end

    always_comb begin
        access  = 1'b0;
        op_done = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_ACCESS: access  = 1'b1;
            ST_REPORT: op_done = 1'b1;
            default:   ;
        endcase
    end

    always_comb begin
        cmd.is_read = frame_q[RD_BIT];
        cmd.phy     = frame_q[PHY_LSB +: ADDR_W];
        cmd.regn    = frame_q[REG_LSB +: ADDR_W];
        cmd.data    = frame_q[DATA_W-1:0];
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    assert_accept_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!op_done ##1 op_done));

    assert_busy_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPORT) |=> $stable(frame_q));

endmodule

// File: rtl/mphy_regfile.sv
module mphy_regfile
    import mphy_pkg::*;
#(
    parameter logic [15:0] PHY_ID_HI = 16'h0A5C,
    parameter logic [15:0] PHY_ID_LO = 16'h73D1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  mgmt_cmd_t         cmd,
    input  logic              link_up,
    output logic [DATA_W-1:0] rd_value
);

    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, stat_nx;
    logic [EVT_W-1:0]  isrc_q, imask_q, isrc_nx;
    logic              link_prev, link_rise, link_fall;
    logic              hit, wr_en, rd_clr;

    assign hit       = (cmd.phy == '0);
    assign wr_en     = access && !cmd.is_read && hit;
    assign rd_clr    = access &&  cmd.is_read && hit && (cmd.regn == REG_ISRC);
    assign link_rise =  link_up && !link_prev;
    assign link_fall = !link_up &&  link_prev;

    always_comb begin
        stat_nx = stat_q;
        if (wr_en && cmd.regn == REG_CTRL && cmd.data[CTRL_AN_BIT])
            stat_nx = stat_nx | STAT_ANOK;
        if (link_rise) stat_nx = stat_nx | STAT_LINK;
        if (link_fall) stat_nx = stat_nx & ~STAT_LINK;
    end

    always_comb begin
        isrc_nx = rd_clr ? '0 : isrc_q;
        if (link_rise) isrc_nx = isrc_nx | EVT_UP;
        if (link_fall) isrc_nx = isrc_nx | EVT_DOWN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= CTRL_RST;
            stat_q    <= STAT_RST;
            adv_q     <= ADV_RST;
            isrc_q    <= '0;
            imask_q   <= '0;
            link_prev <= 1'b0;
        end else begin
            link_prev <= link_up;
            stat_q    <= stat_nx;
            isrc_q    <= isrc_nx;
            if (wr_en && cmd.regn == REG_CTRL)  ctrl_q  <= cmd.data & CTRL_KEEP;
            if (wr_en && cmd.regn == REG_ADV)   adv_q   <= (cmd.data & ADV_KEEP) | ADV_FORCE;
            if (wr_en && cmd.regn == REG_IMASK) imask_q <= cmd.data[EVT_W-1:0];
        end
    end

    always_comb begin
        rd_value = '0;
        if (hit) begin
            case (cmd.regn)
                REG_CTRL:  rd_value = ctrl_q;
                REG_STAT:  rd_value = stat_q;
                REG_IDHI:  rd_value = PHY_ID_HI;
                REG_IDLO:  rd_value = PHY_ID_LO;
                REG_ADV:   rd_value = adv_q;
                REG_ISRC:  rd_value = {{(DATA_W-EVT_W){1'b0}}, isrc_q};
                REG_IMASK: rd_value = {{(DATA_W-EVT_W){1'b0}}, imask_q};
                default:   rd_value = '0;
            endcase
        end
    end

    assert_ctrl_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == '0);

    assert_an_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.regn == REG_CTRL && cmd.data[CTRL_AN_BIT] && !link_fall)
        |=> stat_q[5]);

    assert_adv_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_q & ~ADV_KEEP) == ADV_FORCE);

    assert_link_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_rise |=> (stat_q[5] && stat_q[2] && isrc_q[7] && isrc_q[6]));

    assert_link_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_fall |=> (!stat_q[5] && !stat_q[2] && isrc_q[4]));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !link_rise && !link_fall) |=> (isrc_q == '0));

    assert_foreign_phy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !hit) |=> ($stable(ctrl_q) && $stable(adv_q) && $stable(imask_q)));

endmodule

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
    import mphy_pkg::*;
#(
    parameter logic [15:0] PHY_ID_HI = 16'h0A5C,
    parameter logic [15:0] PHY_ID_LO = 16'h73D1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_wr,
    input  logic [31:0] frame_wdata,
    output logic [31:0] frame_rdata,
    input  logic        link_up,
    output logic        op_done
);

    mgmt_cmd_t         cmd;
    logic              access;
    logic [DATA_W-1:0] rd_value;

    mphy_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .rd_value    (rd_value),
        .frame_q     (frame_rdata),
        .cmd         (cmd),
        .access      (access),
        .op_done     (op_done)
    );

    mphy_regfile #(
        .PHY_ID_HI (PHY_ID_HI),
        .PHY_ID_LO (PHY_ID_LO)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (access),
        .cmd      (cmd),
        .link_up  (link_up),
        .rd_value (rd_value)
    );

endmodule

// File: tb/sim_mgmt_phy_model.sv
module sim_mgmt_phy_model;

    localparam logic [15:0] ID_HI = 16'h0A5C;
    localparam logic [15:0] ID_LO = 16'h73D1;

    logic        clk = 1'b0;
    logic        rst_n, frame_wr, link_up;
    logic [31:0] frame_wdata;
    logic [31:0] frame_rdata;
    logic        op_done;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_isrc, m_mask;

    always #4 clk = ~clk;

    mgmt_phy_model #(.PHY_ID_HI(ID_HI), .PHY_ID_LO(ID_LO)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
        .frame_rdata(frame_rdata), .link_up(link_up), .op_done(op_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] regn, input logic [15:0] d);
        return {2'b10, rd, 1'b1, phy, regn, 2'b11, d};
    endfunction

    function automatic logic [15:0] exp_read(input logic [4:0] phy, input logic [4:0] regn);
        if (phy != 5'd0) return 16'h0;
        case (regn)
            5'd0:    return m_ctrl;
            5'd1:    return m_stat;
            5'd2:    return ID_HI;
            5'd3:    return ID_LO;
            5'd4:    return m_adv;
            5'd29:   return {8'h0, m_isrc};
            5'd30:   return {8'h0, m_mask};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [4:0] phy, input logic [4:0] regn);
        if (phy != 5'd0) return "R10";
        case (regn)
            5'd0, 5'd1: return "R3";
            5'd2, 5'd3: return "R11";
            5'd4:       return "R4";
            5'd29:      return "R9";
            5'd30:      return "R5";
            default:    return "R10";
        endcase
    endfunction

    task automatic model_write(input logic [4:0] phy, input logic [4:0] regn, input logic [15:0] d);
        if (phy == 5'd0) begin
            case (regn)
                5'd0: begin
                    m_ctrl = d & 16'h7980;
                    if (d[12]) m_stat = m_stat | 16'h0020;
                end
                5'd4:  m_adv  = (d & 16'h2D7F) | 16'h0080;
                5'd30: m_mask = d[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic model_link(input bit up);
        if (up) begin
            m_stat = m_stat | 16'h0024;
            m_isrc = m_isrc | 8'hC0;
        end else begin
            m_stat = m_stat & ~16'h0024;
            m_isrc = m_isrc | 8'h10;
        end
    endtask

    // One management access; optional link flip timed onto the access edge,
    // optional stray frame write while busy.
    task automatic run_op(input bit rd, input logic [4:0] phy, input logic [4:0] regn,
                          input logic [15:0] d, input bit flip_link, input bit stray,
                          output logic [31:0] rdata);
        @(negedge clk);
        frame_wr    = 1'b1;
        frame_wdata = mk_word(rd, phy, regn, d);
        @(negedge clk);
        if (stray) frame_wdata = mk_word(1'b0, 5'd0, 5'd30, 16'h005A);
        else       frame_wr    = 1'b0;
        if (flip_link) link_up = ~link_up;
        check("R2 done low after accept", {31'h0, op_done}, 32'h0);
        @(negedge clk);
        frame_wr = 1'b0;
        check("R2 done pulse", {31'h0, op_done}, 32'h1);
        rdata = frame_rdata;
        @(negedge clk);
        check("R2 done single cycle", {31'h0, op_done}, 32'h0);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] regn, input logic [15:0] d);
        logic [31:0] r;
        run_op(1'b0, phy, regn, d, 1'b0, 1'b0, r);
        model_write(phy, regn, d);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] regn, input string tag);
        logic [31:0] r;
        logic [31:0] w;
        w = mk_word(1'b1, phy, regn, 16'hBEEF);
        run_op(1'b1, phy, regn, 16'hBEEF, 1'b0, 1'b0, r);
        check({tag, " R6 read word"}, r, {w[31:16], exp_read(phy, regn)});
        if (phy == 5'd0 && regn == 5'd29) m_isrc = 8'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [15:0] pats [4];
        logic [4:0]  phys [3];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;
        phys[0] = 5'd0;     phys[1] = 5'd1;     phys[2] = 5'd31;

        m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1; m_isrc = 8'h0; m_mask = 8'h0;
        rst_n = 1'b0; frame_wr = 1'b0; frame_wdata = '0; link_up = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 op_done", {31'h0, op_done}, 32'h0);
        check("R1 frame_rdata", frame_rdata, 32'h0);
        rst_n = 1'b1;

        do_read(5'd0, 5'd0,  "R1");
        do_read(5'd0, 5'd1,  "R1");
        do_read(5'd0, 5'd4,  "R1");
        do_read(5'd0, 5'd29, "R1");
        do_read(5'd0, 5'd30, "R1");
        do_read(5'd0, 5'd2,  "R11");
        do_read(5'd0, 5'd3,  "R11");

        // R7: link rises
        @(negedge clk); link_up = 1'b1; model_link(1'b1);
        repeat (2) @(negedge clk);
        do_read(5'd0, 5'd1,  "R7");
        do_read(5'd0, 5'd29, "R7");
        do_read(5'd0, 5'd29, "R9");

        // R8: link falls
        @(negedge clk); link_up = 1'b0; model_link(1'b0);
        repeat (2) @(negedge clk);
        do_read(5'd0, 5'd1,  "R8");
        do_read(5'd0, 5'd29, "R8");

        // Sweep: every register, three PHY addresses, four data patterns
        for (int p = 0; p < 3; p++) begin
            for (int rg = 0; rg < 32; rg++) begin
                for (int k = 0; k < 4; k++) begin
                    do_write(phys[p], rg[4:0], pats[k]);
                    do_read(5'd0, rg[4:0], tag_for(phys[p], rg[4:0]));
                end
            end
        end

        // R3: autonegotiation enable alone sets status bit 5
        do_write(5'd0, 5'd0, 16'h1000);
        do_read(5'd0, 5'd1, "R3");

        // R2: a frame write while busy is ignored
        do_write(5'd0, 5'd30, 16'h0011);
        run_op(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0, 1'b1, r);
        check("R2 busy read ctrl", {16'h0, r[15:0]}, {16'h0, m_ctrl});
        do_read(5'd0, 5'd30, "R2");

        // R9: link rise on the same edge as the clearing read
        do_read(5'd0, 5'd29, "R9");
        run_op(1'b1, 5'd0, 5'd29, 16'h0000, 1'b1, 1'b0, r);
        check("R9 old pending returned", {16'h0, r[15:0]}, {24'h0, m_isrc});
        m_isrc = 8'h0;
        model_link(1'b1);
        do_read(5'd0, 5'd29, "R9");
        do_read(5'd0, 5'd1,  "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule